// File: doc/BRIEF.md
# Reload-and-Match PWM Timer

This block turns an up-counting timer into a single PWM output. The counter climbs from a programmable reload value to all-ones, then wraps back to the reload value. The output level flips twice per period: once when the counter wraps, and once when it steps past a programmable compare value. The reload value sets the period. The compare value sets how long the active phase lasts.

A small write-only register port holds the reload value, the compare value, a direct counter preset and a control word. The control word carries run, output inversion, prescaler enable and the prescaler divide field. A prescaler sits in front of the counter and produces a count-enable tick, which is also brought out as a port.

The usual way to start the block is as follows. While it is stopped, write the reload and compare values, preset the counter to all-ones minus one, then set run. The first wrap then flips the output on the second tick. To reconfigure it, stop it, rewrite the values, re-preset the counter and start it again.

Top module: `rpwm_timer`

## Requirements
- R1: After a synchronous active-low reset, `pwm_out` and `tick` are 0, the block is stopped, the output is not inverted and all registers are 0.
- R2: Tick generation. While stopped, `tick` stays 0. While running with the prescaler disabled, `tick` is 1 on every clock. While running with the prescaler enabled and field value f, `tick` is 1 once every 2^(f+1) clocks.
- R3: On each tick the counter steps up by one. On the tick that leaves all-ones, it loads the reload value instead. One period therefore lasts (all-ones − reload + 1) ticks.
- R4: The internal level flips on the tick that leaves all-ones and on the tick that leaves the compare value. With reload ≤ compare < all-ones, the active phase lasts (compare − reload + 1) ticks and the inactive phase lasts (all-ones − compare) ticks. The output changes on the clock edge that consumes the tick.
- R5: When the compare value equals all-ones, the level flips only once at the wrap, not twice.
- R6: A write to address 2 loads the counter directly, even while the block runs, and takes priority over a tick in the same cycle. After a preset of all-ones minus one and a compare value below that, the first output edge comes on the second tick after run is set.
- R7: Control bit 1 inverts the output. The idle level equals this bit, and the whole waveform is inverted.
- R8: Clearing run freezes the counter and returns `pwm_out` to its idle level one clock later. Setting run again resumes counting from the frozen value.
- R9: Writes to the reload value (address 0) or the compare value (address 1) are ignored while the block runs. Both take effect when written while stopped.
- Register map: address 3 is control. Bit 0 is run, bit 1 is invert, bit 2 is prescaler enable, and bits 5:3 are the divide field f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 reload, 1 compare, 2 counter preset, 3 control |
| wr_data | input | 32 | Write data |
| tick | output | 1 | Count-enable pulse from the prescaler |
| pwm_out | output | 1 | PWM output after polarity |

## Verification
A write takes effect on the clock edge that samples it. Because the tick is combinational from registered state, it changes in the cycle right after the run bit is written. The output flips on the edge that consumes a qualifying tick, so after a start from preset it rises on the second edge, and after a stop it settles one edge later. A behavioural reference model in the bench updates on every rising edge, and the bench compares `tick` and `pwm_out` against it at every falling edge. Directed checks sample the exact falling edges derived above and measure phase lengths in clocks against the formulas.

// File: rtl/rpwm_pkg.sv
// Shared register addresses and control-bit positions for the reload/match PWM timer.
// Assumes a 2-bit register address and a control word at least 6 bits wide.
package rpwm_pkg;
    localparam int ADDR_W      = 2;
    localparam logic [ADDR_W-1:0] A_RELOAD  = 2'd0;
    localparam logic [ADDR_W-1:0] A_COMPARE = 2'd1;
    localparam logic [ADDR_W-1:0] A_PRESET  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL    = 2'd3;
    localparam int C_RUN     = 0;
    localparam int C_INV     = 1;
    localparam int C_PSC_EN  = 2;
    localparam int C_PSC_LSB = 3;
endpackage

// File: rtl/rpwm_prescaler.sv
// Count-enable generator: every clock when bypassed, otherwise once per 2^(f+1) clocks.
// Assumes the divider restarts from zero whenever it is stopped or bypassed.
module rpwm_prescaler #(
    parameter int PSC_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                en_i,
    input  logic [PSC_BITS-1:0] field_i,
    output logic                tick_o
);
    localparam int DIV_W = 1 << PSC_BITS;

    logic [DIV_W-1:0]  div_q;
    logic [DIV_W:0]    one_hot;
    logic [PSC_BITS:0] shamt;
    logic [DIV_W-1:0]  limit;

    // Terminal count for the selected divide ratio.
    always_comb begin
        shamt   = {1'b0, field_i} + {{PSC_BITS{1'b0}}, 1'b1};
        one_hot = {{DIV_W{1'b0}}, 1'b1} << shamt;
        limit   = one_hot[DIV_W-1:0] - {{(DIV_W-1){1'b0}}, 1'b1};
        tick_o  = run_i && (!en_i || (div_q == limit));
    end

    // Divider counter, cleared when idle, bypassed or wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || !en_i || tick_o) div_q <= '0;
        else                                      div_q <= div_q + 1'b1;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && en_i) |=> (!tick_o || !$stable(en_i) || !$stable(field_i)));
endmodule

// File: rtl/rpwm_counter.sv
// Up-counter with auto-reload at all-ones and wrap/compare event outputs.
// Assumes a preset write wins over a tick in the same cycle; a wrap suppresses the compare event.
module rpwm_counter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [WIDTH-1:0] reload_i,
    input  logic [WIDTH-1:0] compare_i,
    input  logic             preset_we_i,
    input  logic [WIDTH-1:0] preset_i,
    output logic             wrap_ev_o,
    output logic             cmp_ev_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;

    // Events are flagged on the tick that leaves all-ones or the compare value.
    always_comb begin
        wrap_ev_o = tick_i && (cnt_q == TOP);
        cmp_ev_o  = tick_i && (cnt_q == compare_i) && (cnt_q != TOP);
    end

    // Counter register: preset, reload on wrap, or increment on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (preset_we_i) cnt_q <= preset_i;
        else if (wrap_ev_o)  cnt_q <= reload_i;
        else if (tick_i)     cnt_q <= cnt_q + 1'b1;
    end

    // R3
    reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_q == TOP && !preset_we_i) |=> (cnt_q == $past(reload_i)));
    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_q != TOP && !preset_we_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !preset_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rpwm_wave.sv
// Output stage: holds the internal level, flips it on events and applies polarity.
// Assumes the level is forced back to zero whenever the timer is stopped.
module rpwm_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic inv_i,
    input  logic wrap_ev_i,
    input  logic cmp_ev_i,
    output logic pwm_o
);
    logic lvl_q;

    // Internal level: cleared when stopped, flipped on either event.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)         lvl_q <= 1'b0;
        else if (wrap_ev_i || cmp_ev_i) lvl_q <= ~lvl_q;
    end

    // Polarity applied at the pin.
    assign pwm_o = lvl_q ^ inv_i;

    // R5
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wrap_ev_i, cmp_ev_i}));
    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && $stable(inv_i)) |=> (pwm_o == inv_i));
endmodule

// File: rtl/rpwm_timer.sv
// Top of the reload/match PWM timer: register write port, prescaler, counter and output stage.
// Assumes reload and compare are only updated while stopped; control and preset are always writable.
module rpwm_timer
    import rpwm_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int PSC_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic              tick,
    output logic              pwm_out
);
    logic [WIDTH-1:0]    reload_q, compare_q;
    logic                run_q, inv_q, psc_en_q;
    logic [PSC_BITS-1:0] psc_f_q;
    logic                preset_we, wrap_ev, cmp_ev;

    assign preset_we = wr_en && (wr_addr == A_PRESET);

    // Register file; period-defining values are locked while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q  <= '0;
            compare_q <= '0;
            run_q     <= 1'b0;
            inv_q     <= 1'b0;
            psc_en_q  <= 1'b0;
            psc_f_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_RELOAD && !run_q)  reload_q  <= wr_data;
            if (wr_addr == A_COMPARE && !run_q) compare_q <= wr_data;
            if (wr_addr == A_CTRL) begin
                run_q    <= wr_data[C_RUN];
                inv_q    <= wr_data[C_INV];
                psc_en_q <= wr_data[C_PSC_EN];
                psc_f_q  <= wr_data[C_PSC_LSB +: PSC_BITS];
            end
        end
    end

    rpwm_prescaler #(.PSC_BITS(PSC_BITS)) u_psc (
        .clk(clk), .rst_n(rst_n), .run_i(run_q), .en_i(psc_en_q),
        .field_i(psc_f_q), .tick_o(tick)
    );

    rpwm_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reload_i(reload_q),
        .compare_i(compare_q), .preset_we_i(preset_we), .preset_i(wr_data),
        .wrap_ev_o(wrap_ev), .cmp_ev_o(cmp_ev)
    );

    rpwm_wave u_wave (
        .clk(clk), .rst_n(rst_n), .run_i(run_q), .inv_i(inv_q),
        .wrap_ev_i(wrap_ev), .cmp_ev_i(cmp_ev), .pwm_o(pwm_out)
    );

    // R9
    locked_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && wr_en && wr_addr == A_RELOAD) |=> $stable(reload_q));
    // R9
    locked_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && wr_en && wr_addr == A_COMPARE) |=> $stable(compare_q));
    // R2
    no_tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q) |-> !tick);
endmodule

// File: tb/rpwm_timer_test.sv
module rpwm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tick, pwm_out;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    rpwm_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                    .wr_data(wr_data), .tick(tick), .pwm_out(pwm_out));

    always #5 clk = ~clk;

    // Behavioural reference state.
    bit          m_run, m_inv, m_pen, m_lvl;
    int          m_pf, m_div;
    logic [31:0] m_rel, m_cmp, m_cnt;

    function automatic bit m_tick();
        return m_run && (!m_pen || m_div == (1 << (m_pf + 1)) - 1);
    endfunction

    always @(posedge clk) begin
        bit t;
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_inv = 0; m_pen = 0; m_lvl = 0; m_pf = 0; m_div = 0;
            m_rel = 0; m_cmp = 0; m_cnt = 0;
        end else begin
            t = m_tick();
            if (!m_run) m_lvl = 0;
            else if (t && (m_cnt == 32'hFFFF_FFFF || m_cnt == m_cmp)) m_lvl = !m_lvl;
            if (!m_run || !m_pen || t) m_div = 0; else m_div++;
            if (wr_en && wr_addr == 2) m_cnt = wr_data;
            else if (t) m_cnt = (m_cnt == 32'hFFFF_FFFF) ? m_rel : m_cnt + 1;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: if (!m_run) m_rel = wr_data;
                    2'd1: if (!m_run) m_cmp = wr_data;
                    2'd3: begin
                        m_run = wr_data[0]; m_inv = wr_data[1];
                        m_pen = wr_data[2]; m_pf = int'(wr_data[5:3]);
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Every-cycle comparison with the reference model.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check(tick == m_tick(), "R2 tick vs model", int'(tick), int'(m_tick()));
            check(pwm_out == (m_lvl ^ m_inv), "R4/R8 pwm vs model",
                  int'(pwm_out), int'(m_lvl ^ m_inv));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 50000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int hi, output int lo);
        while (pwm_out) @(negedge clk);
        while (!pwm_out) @(negedge clk);
        hi = 0;
        while (pwm_out) begin hi++; @(negedge clk); end
        lo = 0;
        while (!pwm_out) begin lo++; @(negedge clk); end
    endtask

    task automatic count_ticks(int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            if (tick) k++;
            @(negedge clk);
        end
    endtask

    initial begin
        int hi, lo, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == 0, "R1 pwm after reset", int'(pwm_out), 0);
        check(tick == 0, "R1 tick after reset", int'(tick), 0);
        cmp_on = 1'b1;

        // Period 10, active 4, no prescaler.
        wr(0, 32'hFFFF_FFF6);
        wr(1, 32'hFFFF_FFF9);
        wr(2, 32'hFFFF_FFFE);
        wr(3, 32'h1);
        check(pwm_out == 0, "R6 pwm at start edge", int'(pwm_out), 0);
        @(negedge clk);
        check(pwm_out == 0, "R6 pwm after first tick", int'(pwm_out), 0);
        @(negedge clk);
        check(pwm_out == 1, "R6 pwm after second tick", int'(pwm_out), 1);
        measure(hi, lo);
        check(hi == 4, "R4 active phase", hi, 4);
        check(lo == 6, "R4 inactive phase", lo, 6);
        check(hi + lo == 10, "R3 period", hi + lo, 10);
        count_ticks(20, k);
        check(k == 20, "R2 tick every clock", k, 20);

        // Reload write while running is ignored.
        wr(0, 32'hFFFF_FFF0);
        wr(1, 32'hFFFF_FFF1);
        measure(hi, lo);
        check(hi == 4 && lo == 6, "R9 period unchanged", hi + lo, 10);

        // Stop.
        wr(3, 32'h0);
        check(tick == 0, "R2 no tick when stopped", int'(tick), 0);
        @(negedge clk);
        check(pwm_out == 0, "R8 idle after stop", int'(pwm_out), 0);
        count_ticks(10, k);
        check(k == 0, "R2 no ticks while stopped", k, 0);

        // Period 8, active 2, divide by 4.
        wr(0, 32'hFFFF_FFF8);
        wr(2, 32'hFFFF_FFFE);
        wr(3, 32'h1 | 32'h4 | (32'd1 << 3));
        measure(hi, lo);
        check(hi == 8, "R2 active with divide 4", hi, 8);
        check(lo == 24, "R2 inactive with divide 4", lo, 24);
        count_ticks(40, k);
        check(k == 10, "R2 tick rate divide 4", k, 10);

        // Inverted output.
        wr(3, 32'h0);
        wr(3, 32'h2);
        @(negedge clk);
        check(pwm_out == 1, "R7 idle level inverted", int'(pwm_out), 1);
        wr(2, 32'hFFFF_FFFE);
        wr(3, 32'h3);
        measure(hi, lo);
        check(lo == 2, "R7 inverted active phase", lo, 2);
        check(hi == 6, "R7 inverted inactive phase", hi, 6);

        // Compare at all-ones: one flip per wrap.
        wr(3, 32'h0);
        wr(0, 32'hFFFF_FFFB);
        wr(1, 32'hFFFF_FFFF);
        wr(2, 32'hFFFF_FFFE);
        wr(3, 32'h1);
        measure(hi, lo);
        check(hi == 5 && lo == 5, "R5 single flip per wrap", hi * 10 + lo, 55);

        // Freeze and resume without preset.
        repeat (3) @(negedge clk);
        wr(3, 32'h0);
        repeat (6) @(negedge clk);
        wr(3, 32'h1);
        measure(hi, lo);
        check(hi == 5 && lo == 5, "R8 resume keeps period", hi * 10 + lo, 55);

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule